// File: doc/BRIEF.md
# Serial Configuration-Register Read Master

This block is an SPI master that fetches 32-bit configuration and status words from an external clock-synthesizer peripheral. It uses four wires: a serial clock, a command line, a return line, and a latch-enable strobe. Latch-enable is low while bits move and high at all other times.

A host makes one read by pulsing `req_valid` together with a 4-bit register number. The block then runs one transaction in this order:

- It drops latch-enable and sends a 32-bit read command, least-significant bit first.
- It raises latch-enable for a programmable number of system clocks so the peripheral can prepare its answer.
- It drops latch-enable again and clocks in 32 response bits, least-significant bit first.
- It raises latch-enable and returns the word with a one-cycle `done` strobe.

A hold that is too short makes the peripheral return only an echo of the address, so the hold length is a runtime input. The serial clock half-period is also a runtime input, counted in system clocks, so the bus can run well below 1 MHz.

After reset the block holds latch-enable high through a power-up window, so that the peripheral loads its defaults while it leaves power-down. Whenever register 8, the read-only status word, is read, its lock, awake and input-activity flags are decoded onto dedicated outputs.

Top module: `spi_regread_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and for `PWRUP_CYCLES` (default 16) edges after it goes high, the outputs are: `spi_le`=1, `spi_sclk`=0, `spi_mosi`=0, `busy`=1, `done`=0, `rd_data`=0 and all status outputs 0. A request made in that window is dropped. A reset during a transfer aborts the transfer.
- R2: The command word is 0x0000_00?E: bits [3:0] are 0xE, bits [7:4] are the register index, and all other bits are 0. It is sent LSB first on `spi_mosi`. `spi_mosi` changes only when `spi_sclk` falls, and `spi_sclk` idles low.
- R3: Call the cycle after acceptance t=0, and let D be `sclk_half_div` (0 is treated as 1). For t<64·D: `spi_le`=0, `spi_sclk`=(t/D) mod 2, and `spi_mosi`=command bit t/(2·D).
- R4: Let H be `le_hold_cycles` (0 is treated as 1). For 64·D ≤ t < 64·D+H: `spi_le`=1, `spi_sclk`=0, `spi_mosi`=0.
- R5: For 64·D+H ≤ t < 128·D+H: `spi_le`=0, `spi_mosi`=0, and `spi_sclk` follows the same pattern as in R3 starting from low. `spi_miso` is sampled on each rising edge, and the first bit sampled becomes bit 0 of the result.
- R6: At t=128·D+H, `done`=1 for exactly one cycle, `spi_le`=1 and `busy`=0. `rd_data` takes the received word at that cycle and keeps it until the next `done` or reset.
- R7: `busy` is 1 from t=0 through t=128·D+H−1. A request made while `busy` is 1 is ignored.
- R8: When `done` follows a read of index 8, the outputs update in the same cycle: `stat_pll_lock` takes bit 6, `stat_awake` takes bit 7, and `stat_activity` takes bits [27:25]. Reads of any other index leave these outputs unchanged.
- R9: `sclk_half_div`, `le_hold_cycles` and the index are sampled only when a request is accepted. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request, taken when idle |
| req_index | input | 4 | Register number to read |
| sclk_half_div | input | DIV_W | System clocks per serial-clock half period |
| le_hold_cycles | input | HOLD_W | Latch-enable high time between command and readback |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Command data to the peripheral |
| spi_miso | input | 1 | Response data from the peripheral |
| spi_le | output | 1 | Latch enable, low during shifting |
| busy | output | 1 | Power-up window or transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 32 | Last word received |
| stat_pll_lock | output | 1 | Lock flag from the last status read |
| stat_awake | output | 1 | Not-sleeping flag from the last status read |
| stat_activity | output | 3 | Input-activity flags from the last status read |

## Verification
The bench targets four kinds of boundary.

- **Minimum settings.** With divider and hold both at 0 (treated as 1), an off-by-one in the half-period counter would stretch the clock or drop a bit, and a wrong hold count would shorten the latch gap to nothing.
- **Events during a transfer.** A second request and changed settings arrive while a read is running. A design that re-armed or re-sampled here would restart, or would change its clock rate part-way through the word.
- **Status register.** Register 8 is read twice with different flag patterns and then a different register is read. This catches bit-order mistakes in the flag decode, and flags that get overwritten by reads of other registers.
- **Reset.** A reset in the middle of a transfer must return the outputs to the power-up state. Requests made during the power-up window must be dropped.

// File: rtl/spi_rd_pkg.sv
// Shared constants, state type and command builder for the SPI register-read
// master. Assumes 32-bit words and a 4-bit register index.
package spi_rd_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned IDX_W      = 4;
    localparam logic [3:0]  READ_OP    = 4'hE;
    localparam int unsigned STATUS_IDX = 8;
    localparam int unsigned LOCK_BIT   = 6;
    localparam int unsigned AWAKE_BIT  = 7;
    localparam int unsigned ACT_LSB    = 25;
    localparam int unsigned ACT_W      = 3;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_CMD,
        ST_HOLD,
        ST_RDBK
    } rd_state_e;

    // Read command: opcode nibble low, index nibble above it, zeros elsewhere.
    function automatic logic [WORD_W-1:0] build_read_cmd(input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[3:0] = READ_OP;
        w[7:4] = idx;
        return w;
    endfunction
endpackage

// File: rtl/spi_rd_pacer.sv
// Half-period timer for the serial clock. While run is high it counts
// system clocks and flags the last cycle of every half period.
// Assumes half_len is nonzero and stable while run is high.
module spi_rd_pacer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             half_end
);
    logic [DIV_W-1:0] cnt_q;

    assign half_end = run && (cnt_q == half_len - DIV_W'(1));

    // Count within the current half period; clear when idle or at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (half_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half_len));
endmodule

// File: rtl/spi_rd_serializer.sv
// Bit engine: drives the serial clock from half-period ticks, shifts the
// loaded word out LSB first on falling edges and shifts received bits in
// on rising edges (LSB first). Assumes W is a power of two.
module spi_rd_serializer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         half_end,
    input  logic         rx_en,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         last_fall,
    output logic [W-1:0] rx_word
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic [CW-1:0] bit_q;
    logic          sclk_q;
    logic          rise;
    logic          fall;

    assign rise      = half_end && !sclk_q;
    assign fall      = half_end && sclk_q;
    assign last_fall = fall && (bit_q == CW'(W - 1));
    assign sclk      = sclk_q;
    assign mosi      = tx_q[0];
    assign rx_word   = rx_q;

    // Outgoing shifter: load a command, advance one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (fall) begin
            tx_q <= tx_q >> 1;
        end
    end

    // Serial clock level and count of completed bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            bit_q  <= '0;
        end else if (load) begin
            sclk_q <= 1'b0;
            bit_q  <= '0;
        end else if (rise) begin
            sclk_q <= 1'b1;
        end else if (fall) begin
            sclk_q <= 1'b0;
            bit_q  <= bit_q + CW'(1);
        end
    end

    // Incoming shifter: first sampled bit ends in position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise && rx_en) begin
            rx_q <= {miso, rx_q[W-1:1]};
        end
    end

    // R5
    rx_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && rx_en) |=> $stable(rx_q));
endmodule

// File: rtl/spi_rd_status_decode.sv
// Holds the flags of the read-only status word. Loads them when capture is
// high and otherwise keeps the last decoded values.
module spi_rd_status_decode
    import spi_rd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [W-1:0]     word,
    output logic             lock,
    output logic             awake,
    output logic [ACT_W-1:0] activity
);
    // Latch the flag fields from a completed status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock     <= 1'b0;
            awake    <= 1'b0;
            activity <= '0;
        end else if (capture) begin
            lock     <= word[LOCK_BIT];
            awake    <= word[AWAKE_BIT];
            activity <= word[ACT_LSB +: ACT_W];
        end
    end

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(activity) && $stable(lock) && $stable(awake)));
    // R8
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (activity == $past(word[ACT_LSB +: ACT_W])));
endmodule

// File: rtl/spi_regread_ctrl.sv
// SPI register-read master. Sequences power-up hold, command shift, latch
// hold and readback; returns the word with a one-cycle done strobe. Assumes
// PWRUP_CYCLES >= 1; zero divider or hold inputs are treated as one.
module spi_regread_ctrl
    import spi_rd_pkg::*;
#(
    parameter int DIV_W        = 16,
    parameter int HOLD_W       = 16,
    parameter int PWRUP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DIV_W-1:0]  sclk_half_div,
    input  logic [HOLD_W-1:0] le_hold_cycles,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_le,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              stat_pll_lock,
    output logic              stat_awake,
    output logic [ACT_W-1:0]  stat_activity
);
    localparam int PW_W = $clog2(PWRUP_CYCLES + 1);

    rd_state_e         state_q;
    logic [PW_W-1:0]   pw_cnt_q;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic [DIV_W-1:0]  div_q;
    logic [IDX_W-1:0]  idx_q;
    logic              le_q;
    logic              done_q;
    logic [WORD_W-1:0] rd_q;

    logic              accept;
    logic              run;
    logic              half_end;
    logic              last_fall;
    logic [WORD_W-1:0] rx_word;
    logic              stat_capture;

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign run          = (state_q == ST_CMD) || (state_q == ST_RDBK);
    assign stat_capture = (state_q == ST_RDBK) && last_fall && (idx_q == IDX_W'(STATUS_IDX));

    assign spi_le  = le_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;

    spi_rd_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_len (div_q),
        .half_end (half_end)
    );

    spi_rd_serializer #(.W(WORD_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (build_read_cmd(req_index)),
        .half_end  (half_end),
        .rx_en     (state_q == ST_RDBK),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .last_fall (last_fall),
        .rx_word   (rx_word)
    );

    spi_rd_status_decode #(.W(WORD_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (stat_capture),
        .word     (rx_word),
        .lock     (stat_pll_lock),
        .awake    (stat_awake),
        .activity (stat_activity)
    );

    // Transaction sequencer: power-up window, command, hold, readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_PWRUP;
            pw_cnt_q   <= '0;
            hold_cnt_q <= '0;
            hold_q     <= HOLD_W'(1);
            div_q      <= DIV_W'(1);
            idx_q      <= '0;
            le_q       <= 1'b1;
            done_q     <= 1'b0;
            rd_q       <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_PWRUP: begin
                    if (pw_cnt_q == PW_W'(PWRUP_CYCLES - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        pw_cnt_q <= pw_cnt_q + PW_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_CMD;
                        le_q    <= 1'b0;
                        idx_q   <= req_index;
                        div_q   <= (sclk_half_div == '0) ? DIV_W'(1) : sclk_half_div;
                        hold_q  <= (le_hold_cycles == '0) ? HOLD_W'(1) : le_hold_cycles;
                    end
                end
                ST_CMD: begin
                    if (last_fall) begin
                        state_q    <= ST_HOLD;
                        le_q       <= 1'b1;
                        hold_cnt_q <= '0;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt_q == hold_q - HOLD_W'(1)) begin
                        state_q <= ST_RDBK;
                        le_q    <= 1'b0;
                    end else begin
                        hold_cnt_q <= hold_cnt_q + HOLD_W'(1);
                    end
                end
                ST_RDBK: begin
                    if (last_fall) begin
                        state_q <= ST_IDLE;
                        le_q    <= 1'b1;
                        done_q  <= 1'b1;
                        rd_q    <= rx_word;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    le_low_while_clocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_le);
    // R2
    mosi_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_le && !busy));
    // R7
    busy_covers_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_le |-> busy);
endmodule

// File: tb/tb_spi_regread_ctrl.sv
// Bench: a behavioural timeline model predicts every output on every clock
// and acts as the peripheral on spi_miso.
module tb_spi_regread_ctrl;
    import spi_rd_pkg::*;

    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_index = '0;
    logic [15:0] div_in = 16'd1;
    logic [15:0] hold_in = 16'd1;
    logic        miso = 1'b1;

    logic        sclk, mosi, le, busy, done, lock, awake;
    logic [31:0] rd_data;
    logic [2:0]  act;

    always #4 clk = ~clk;

    spi_regread_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .sclk_half_div(div_in), .le_hold_cycles(hold_in),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_le(le),
        .busy(busy), .done(done), .rd_data(rd_data),
        .stat_pll_lock(lock), .stat_awake(awake), .stat_activity(act)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Peripheral status word; bench changes it only while idle.
    logic [31:0] stat8 = 32'h0A01_2340;

    function automatic logic [31:0] resp_of(input logic [3:0] i);
        if (i == 4'd8) return stat8;
        return 32'h1234_5000 ^ ({28'h0, i} * 32'h0101_0101) ^ {24'h0, i, 4'hE};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
        n_run++;
        if (actv !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, actv, expv, $time);
        end
    endtask

    // Inputs as seen at the last rising edge.
    logic        e_rst = 1'b0, e_req = 1'b0;
    logic [3:0]  e_idx = '0;
    logic [15:0] e_div = 16'd1, e_hold = 16'd1;
    always @(posedge clk) begin
        e_rst  <= rst_n;
        e_req  <= req_valid;
        e_idx  <= req_index;
        e_div  <= div_in;
        e_hold <= hold_in;
    end

    // Reference timeline, advanced and compared once per clock.
    int          t = -1, pu = P, md = 1, mh = 1;
    logic [3:0]  midx = '0;
    logic [31:0] exp_rd = '0;
    logic        x_lock = 1'b0, x_awake = 1'b0;
    logic [2:0]  x_act = '0;

    always @(negedge clk) begin
        int          tend, t0;
        logic [31:0] cmd, word;
        logic        xb, xl, xs, xm, xd;
        string       tg;
        if (!e_rst) begin
            pu = P; t = -1; exp_rd = '0; x_lock = 0; x_awake = 0; x_act = '0;
        end else if (pu > 0) begin
            pu--;
        end else if (t >= 0 && t < 128 * md + mh) begin
            t++;
        end else if (e_req) begin
            t = 0;
            md = (e_div == 0) ? 1 : int'(e_div);
            mh = (e_hold == 0) ? 1 : int'(e_hold);
            midx = e_idx;
        end else begin
            t = -1;
        end
        tend = 128 * md + mh;
        t0   = 64 * md + mh;
        cmd  = {24'h0, midx, 4'hE};
        word = resp_of(midx);
        xb = 1; xl = 1; xs = 0; xm = 0; xd = 0; tg = "R1";
        if (e_rst && pu == 0) begin
            if (t < 0) begin
                xb = 0; tg = "R7";
            end else if (t < 64 * md) begin
                xl = 0; xs = ((t / md) % 2) == 1; xm = cmd[t / (2 * md)]; tg = "R3";
            end else if (t < t0) begin
                tg = "R4";
            end else if (t < tend) begin
                xl = 0; xs = (((t - t0) / md) % 2) == 1; tg = "R5";
            end else begin
                xb = 0; xd = 1; tg = "R6";
                exp_rd = word;
                if (midx == 4'd8) begin
                    x_lock = word[6]; x_awake = word[7]; x_act = word[27:25];
                end
            end
        end
        chk(tg == "R6" ? "R6" : (tg == "R1" ? "R1" : "R7"), "busy", busy, xb);
        chk(tg, "spi_le", le, xl);
        chk(tg, "spi_sclk", sclk, xs);
        chk(tg == "R3" ? "R2" : tg, "spi_mosi", mosi, xm);
        chk(tg == "R1" ? "R1" : "R6", "done", done, xd);
        chk("R5", "rd_data", rd_data, exp_rd);
        chk("R8", "status", {27'h0, lock, awake, act}, {27'h0, x_lock, x_awake, x_act});
        // Peripheral: present response bit k during readback bit period k.
        if (e_rst && pu == 0 && t >= t0 && t < tend) miso = word[(t - t0) / (2 * md)];
        else miso = 1'b1;
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic start_read(input logic [3:0] i, input int d, input int h);
        req_valid = 1'b1; req_index = i; div_in = 16'(d); hold_in = 16'(h);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] i, input int d, input int h);
        start_read(i, d, h);
        wait_idle();
    endtask

    task automatic report();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: request inside the power-up window is dropped
        repeat (3) @(negedge clk);
        start_read(4'd2, 1, 1);
        wait_idle();
        // R2 R3 R4 R5 R6: plain read with divider 2, hold 4
        do_read(4'd3, 2, 4);
        // R8 R3 R4: status read at minimum settings (0 treated as 1)
        do_read(4'd8, 0, 0);
        // R7 R9: extra request and new settings during a transfer
        start_read(4'd5, 3, 2);
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_index = 4'd7; div_in = 16'd1; hold_in = 16'd9;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        do_read(4'd0, 1, 1);
        // R8: second status pattern, then a non-status read leaves flags
        stat8 = 32'h0400_0081;
        do_read(4'd8, 2, 3);
        do_read(4'd4, 1, 2);
        // R1: reset in the middle of a transfer
        start_read(4'd6, 2, 1);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_idle();
        do_read(4'd1, 1, 2);
        repeat (5) @(negedge clk);
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual busy=%b expected completion", busy);
            report();
        end
    end
endmodule